// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the processor-facing side of an asynchronous serial port. A chip-select, a single register-select line and separate read and write strobes reach four byte registers through only two addresses: the direction of the access picks between a write-only and a read-only register at each address. Address 0 takes the byte to transmit on a write and returns the last received byte on a read. Address 1 takes the configuration byte on a write and returns the status byte on a read.

The block holds the configuration byte and decodes it into the settings that the serial engines need: bit-rate select, character length, parity enable and sense, and stop-bit count. It exchanges bytes with the transmit and receive engines over plain handshake ports. It assembles the status byte from the holding-register flags and three sticky error bits.

The shared data bus is split into an input, an output and an output enable, so that the pad ring can build the three-state driver. The output enable is high only during a decoded read. The strobes are sampled on the clock, and each cycle with a strobe high counts as one access.

Top module: `ser_bus_front`

## Requirements
- R1: When `cs` is low, or when `rd` and `wr` are both high or both low, no register changes, no read side effect occurs and `bus_oe` is 0 (with `bus_dout` = 0).
- R2: A write with `rsel`=0 while the transmit holding register is empty loads `bus_din` into it. From the next cycle `tx_valid` is 1, `tx_data` carries the byte and status bit 0 (transmit empty) reads 0.
- R3: A write with `rsel`=0 while the transmit holding register is full is ignored: `tx_data` keeps the earlier byte.
- R4: A cycle with `tx_valid` and `tx_ready` both high hands the byte to the engine. From the next cycle `tx_valid` is 0 and status bit 0 reads 1.
- R5: A write with `rsel`=1 loads the configuration byte. Its fields: bits [1:0] give `baud_sel`; bits [3:2] give the character length, with 00 = 5 bits through 11 = 8 bits, shown as a count on `char_bits`; bit 4 gives `par_en`; bit 5 gives `par_even`; bit 6 gives `stop_two`. After reset the byte is 0x00.
- R6: A read with `rsel`=0 drives the received byte with `bus_oe`=1 in the same cycle. It clears status bit 1 (receive full) from the next cycle, unless a new byte arrives in that same cycle, in which case the new byte is held and the flag stays 1.
- R7: A read with `rsel`=1 returns the status byte with `bus_oe`=1: bit 0 transmit empty, bit 1 receive full, bit 2 parity error, bit 3 framing error, bit 4 overrun, bits 7:5 zero. After reset the status byte is 0x01.
- R8: An `rx_valid` pulse while the receive holding register is empty (or is being read) stores `rx_data` and sets receive full. It sets status bit 2 if `rx_perr` is high and status bit 3 if `rx_ferr` is high.
- R9: An `rx_valid` pulse while the receive holding register is full and not being read discards the new byte, keeps the held byte and sets status bit 4.
- R10: A status read clears bits 2 to 4 from the next cycle. An error flagged by `rx_valid` in the same cycle survives the clear. The read itself returns the bits as they stood before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rsel | input | 1 | Register select (0: data, 1: configuration/status) |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| bus_din | input | 8 | Write data from the host bus |
| bus_dout | output | 8 | Read data to the host bus |
| bus_oe | output | 1 | Read data enable for the pad driver |
| tx_data | output | 8 | Byte offered to the transmit engine |
| tx_valid | output | 1 | Transmit holding register is full |
| tx_ready | input | 1 | Transmit engine accepts the byte |
| rx_data | input | 8 | Byte from the receive engine |
| rx_valid | input | 1 | One-cycle pulse: `rx_data` is a complete character |
| rx_perr | input | 1 | Parity error on the character, qualified by `rx_valid` |
| rx_ferr | input | 1 | Framing error on the character, qualified by `rx_valid` |
| baud_sel | output | 2 | Bit-rate select |
| char_bits | output | 4 | Character length in bits (5 to 8) |
| par_en | output | 1 | Parity generate and check enable |
| par_even | output | 1 | Even parity when 1 |
| stop_two | output | 1 | Two stop bits when 1 |

## Verification
A corrupt holding flag shows at the ports one cycle after the access that caused it. A transmit flag stuck full blocks the next load and freezes `tx_data`. A receive flag that fails to clear turns the next arriving byte into a spurious overrun, visible in status bit 4 on the following status read. A wrong decode shows in the same cycle as a driven bus outside a read or a wrong byte on `bus_dout`. A configuration byte loaded into the wrong field shows on the decoded outputs one cycle after the write.

// File: rtl/ser_bus_pkg.sv
package ser_bus_pkg;

    localparam int unsigned BYTE_W = 8;

    // status byte bit positions (software-visible layout)
    localparam int unsigned ST_TXE  = 0;
    localparam int unsigned ST_RXF  = 1;
    localparam int unsigned ST_PERR = 2;
    localparam int unsigned ST_FERR = 3;
    localparam int unsigned ST_OVR  = 4;

    // configuration byte layout, most significant field first
    typedef struct packed {
        logic       spare;
        logic       stop_two;
        logic       par_even;
        logic       par_en;
        logic [1:0] len_code;
        logic [1:0] baud;
    } cfg_t;

    // minimum character length encoded by len_code == 0
    localparam int unsigned CHAR_MIN = 5;

endpackage

// File: rtl/ser_bus_decode.sv
module ser_bus_decode (
    input  logic cs,
    input  logic rsel,
    input  logic rd,
    input  logic wr,
    output logic wr_thr,
    output logic wr_cfg,
    output logic rd_rhr,
    output logic rd_sts,
    output logic rd_any
);
    logic rd_only;
    logic wr_only;

    always_comb begin
        rd_only = cs && rd && !wr;
        wr_only = cs && wr && !rd;
        wr_thr  = wr_only && !rsel;
        wr_cfg  = wr_only &&  rsel;
        rd_rhr  = rd_only && !rsel;
        rd_sts  = rd_only &&  rsel;
        rd_any  = rd_only;
    end
endmodule

// File: rtl/ser_bus_txhold.sv
module ser_bus_txhold #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
    } thr_t;

    thr_t st_d;
    thr_t st_q;

    always_comb begin
        st_d = st_q;
        if (take && st_q.full) begin
            st_d.full = 1'b0;
        end
        // a load while still full is dropped, even if the engine takes now
        if (load && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full = st_q.full;
    assign data = st_q.data;
endmodule

// File: rtl/ser_bus_cfgreg.sv
module ser_bus_cfgreg
    import ser_bus_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_byte,
    output logic [1:0]    baud_sel,
    output logic [3:0]    char_bits,
    output logic          par_en,
    output logic          par_even,
    output logic          stop_two
);
    localparam logic [3:0] LEN_BASE = 4'(CHAR_MIN);

    logic [DW-1:0] cfg_d;
    logic [DW-1:0] cfg_q;
    cfg_t          view;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        view      = cfg_t'(cfg_q[7:0]);
        baud_sel  = view.baud;
        char_bits = LEN_BASE + {2'b00, view.len_code};
        par_en    = view.par_en;
        par_even  = view.par_even;
        stop_two  = view.stop_two;
    end

    assign cfg_byte = cfg_q;
endmodule

// File: rtl/ser_bus_rxstat.sv
module ser_bus_rxstat #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_rhr,
    input  logic          rd_sts,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    output logic          rx_full,
    output logic [DW-1:0] rhr,
    output logic          perr,
    output logic          ferr,
    output logic          ovr
);
    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
        logic          ovr;
    } rxs_t;

    rxs_t st_d;
    rxs_t st_q;

    always_comb begin
        st_d = st_q;
        if (rd_rhr) begin
            st_d.full = 1'b0;
        end
        if (rd_sts) begin
            st_d.perr = 1'b0;
            st_d.ferr = 1'b0;
            st_d.ovr  = 1'b0;
        end
        // arrivals are applied last so a new event wins over a clear
        if (rx_valid) begin
            if (st_q.full && !rd_rhr) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.full = 1'b1;
                st_d.data = rx_data;
                if (rx_perr) begin
                    st_d.perr = 1'b1;
                end
                if (rx_ferr) begin
                    st_d.ferr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_full = st_q.full;
    assign rhr     = st_q.data;
    assign perr    = st_q.perr;
    assign ferr    = st_q.ferr;
    assign ovr     = st_q.ovr;
endmodule

// File: rtl/ser_bus_front.sv
module ser_bus_front
    import ser_bus_pkg::*;
#(
    parameter int unsigned DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rsel,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    input  logic          rx_perr,
    input  logic          rx_ferr,
    output logic [1:0]    baud_sel,
    output logic [3:0]    char_bits,
    output logic          par_en,
    output logic          par_even,
    output logic          stop_two
);
    logic          wr_thr;
    logic          wr_cfg;
    logic          rd_rhr;
    logic          rd_sts;
    logic          rd_any;
    logic          tx_full;
    logic          rx_full;
    logic [DW-1:0] rhr;
    logic          perr;
    logic          ferr;
    logic          ovr;
    logic [DW-1:0] cfg_byte;
    logic [DW-1:0] sts_byte;

    ser_bus_decode u_dec (
        .cs     (cs),
        .rsel   (rsel),
        .rd     (rd),
        .wr     (wr),
        .wr_thr (wr_thr),
        .wr_cfg (wr_cfg),
        .rd_rhr (rd_rhr),
        .rd_sts (rd_sts),
        .rd_any (rd_any)
    );

    ser_bus_txhold #(.DW(DW)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_thr),
        .wdata (bus_din),
        .take  (tx_ready),
        .full  (tx_full),
        .data  (tx_data)
    );

    ser_bus_cfgreg #(.DW(DW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_cfg),
        .wdata     (bus_din),
        .cfg_byte  (cfg_byte),
        .baud_sel  (baud_sel),
        .char_bits (char_bits),
        .par_en    (par_en),
        .par_even  (par_even),
        .stop_two  (stop_two)
    );

    ser_bus_rxstat #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_rhr   (rd_rhr),
        .rd_sts   (rd_sts),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_perr  (rx_perr),
        .rx_ferr  (rx_ferr),
        .rx_full  (rx_full),
        .rhr      (rhr),
        .perr     (perr),
        .ferr     (ferr),
        .ovr      (ovr)
    );

    always_comb begin
        sts_byte          = '0;
        sts_byte[ST_TXE]  = !tx_full;
        sts_byte[ST_RXF]  = rx_full;
        sts_byte[ST_PERR] = perr;
        sts_byte[ST_FERR] = ferr;
        sts_byte[ST_OVR]  = ovr;
    end

    always_comb begin
        bus_oe   = rd_any;
        bus_dout = '0;
        if (rd_any) begin
            bus_dout = rsel ? sts_byte : rhr;
        end
    end

    assign tx_valid = tx_full;
endmodule

// File: rtl/ser_bus_front_chk.sv
module ser_bus_front_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          wr_thr,
    input logic          wr_cfg,
    input logic          rd_rhr,
    input logic          rd_sts,
    input logic [DW-1:0] bus_din,
    input logic [DW-1:0] tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rx_valid,
    input logic [DW-1:0] cfg_byte,
    input logic [DW-1:0] sts_byte
);
    p_idle_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(cfg_byte));

    p_thr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !tx_valid) |=> (tx_valid && tx_data == $past(bus_din)));

    p_thr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_thr_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_valid);

    p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (cfg_byte == $past(bus_din)));

    p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rhr && !rx_valid) |=> !sts_byte[1]);

    p_txe_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_byte[0] == !tx_valid);

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && sts_byte[1] && !rd_rhr) |=> sts_byte[4]);

    p_sticky_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !rx_valid) |=> (sts_byte[4:2] == 3'b000));
endmodule

bind ser_bus_front ser_bus_front_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .wr_thr   (wr_thr),
    .wr_cfg   (wr_cfg),
    .rd_rhr   (rd_rhr),
    .rd_sts   (rd_sts),
    .bus_din  (bus_din),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .cfg_byte (cfg_byte),
    .sts_byte (sts_byte)
);

// File: tb/tb_ser_bus_front.sv
`timescale 1ns/1ps
module tb_ser_bus_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0;
    logic       rsel = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic       rx_perr = 1'b0;
    logic       rx_ferr = 1'b0;
    logic [1:0] baud_sel;
    logic [3:0] char_bits;
    logic       par_en;
    logic       par_even;
    logic       stop_two;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ser_bus_front dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .baud_sel(baud_sel), .char_bits(char_bits), .par_en(par_en),
        .par_even(par_even), .stop_two(stop_two)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic rs, input logic [7:0] v);
        @(negedge clk);
        cs = 1'b1; rsel = rs; wr = 1'b1; bus_din = v;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic rs, output logic [7:0] v, output logic oe);
        @(negedge clk);
        cs = 1'b1; rsel = rs; rd = 1'b1;
        #2;
        v = bus_dout; oe = bus_oe;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    logic [7:0] rv;
    logic       roe;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset oe", {31'd0, bus_oe}, 32'd0);
        chk("R2 reset tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R5 reset char_bits", {28'd0, char_bits}, 32'd5);
        bus_read(1'b1, rv, roe);
        chk("R7 reset status", {24'd0, rv}, 32'h01);
        chk("R7 status oe", {31'd0, roe}, 32'd1);

        // R5: every configuration byte
        for (int v = 0; v < 256; v++) begin
            bus_write(1'b1, 8'(v));
            chk("R5 cfg fields",
                {17'd0, baud_sel, char_bits, par_en, par_even, stop_two, 5'd0},
                {17'd0, 2'(v & 3), 4'(5 + ((v >> 2) & 3)), 1'((v >> 4) & 1),
                 1'((v >> 5) & 1), 1'((v >> 6) & 1), 5'd0});
        end
        bus_write(1'b1, 8'h2D);

        // R1: deselected or ambiguous strobes change nothing, bus not driven
        @(negedge clk);
        cs = 1'b0; rsel = 1'b1; wr = 1'b1; bus_din = 8'h5A;
        #2 chk("R1 cs low oe", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        wr = 1'b0; rd = 1'b1;
        #2 chk("R1 cs low read oe", {31'd0, bus_oe}, 32'd0);
        chk("R1 cs low dout", {24'd0, bus_dout}, 32'd0);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; wr = 1'b1;
        #2 chk("R1 rd+wr oe", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; wr = 1'b0; rsel = 1'b0;
        chk("R1 cfg unchanged", {24'd0, 2'b00, stop_two, par_even, par_en, char_bits[1:0] - 2'd1, baud_sel},
            32'h2D & 32'h7F ^ 32'h0);
        chk("R1 tx not loaded", {31'd0, tx_valid}, 32'd0);

        // R2/R3/R4: every transmit byte
        for (int v = 0; v < 256; v++) begin
            bus_write(1'b0, 8'(v));
            chk("R2 tx load", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'(v)});
            bus_write(1'b0, 8'(~v));
            chk("R3 write while full ignored", {24'd0, tx_data}, {24'd0, 8'(v)});
            bus_read(1'b1, rv, roe);
            chk("R2 status txe low", {31'd0, rv[0]}, 32'd0);
            tx_take();
            chk("R4 take empties", {31'd0, tx_valid}, 32'd0);
        end
        bus_read(1'b1, rv, roe);
        chk("R4 status txe high", {24'd0, rv}, 32'h01);

        // R6/R8/R10: every receive byte with error pattern from its low bits
        for (int v = 0; v < 256; v++) begin
            rx_push(8'(v), 1'(v & 1), 1'((v >> 1) & 1));
            bus_read(1'b1, rv, roe);
            chk("R8 status after rx", {24'd0, rv},
                {24'd0, 3'b000, 1'b0, 1'((v >> 1) & 1), 1'(v & 1), 1'b1, 1'b1});
            bus_read(1'b0, rv, roe);
            chk("R6 rhr data", {23'd0, roe, rv}, {23'd0, 1'b1, 8'(v)});
            bus_read(1'b1, rv, roe);
            chk("R10 cleared status", {24'd0, rv}, 32'h01);
        end

        // R9: overrun keeps the first byte
        rx_push(8'hA1, 1'b0, 1'b0);
        rx_push(8'hB2, 1'b1, 1'b0);
        bus_read(1'b1, rv, roe);
        chk("R9 overrun status", {24'd0, rv}, 32'h13);
        bus_read(1'b0, rv, roe);
        chk("R9 first byte kept", {24'd0, rv}, 32'hA1);

        // R6: read of holding register in the same cycle as a new byte
        rx_push(8'h31, 1'b0, 1'b0);
        @(negedge clk);
        cs = 1'b1; rsel = 1'b0; rd = 1'b1;
        rx_valid = 1'b1; rx_data = 8'h42;
        #2 chk("R6 same-cycle read old", {24'd0, bus_dout}, 32'h31);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; rx_valid = 1'b0;
        bus_read(1'b1, rv, roe);
        chk("R6 same-cycle full, no overrun", {24'd0, rv}, 32'h03);
        bus_read(1'b0, rv, roe);
        chk("R6 same-cycle new byte", {24'd0, rv}, 32'h42);

        // R10: error arriving during a status read survives
        @(negedge clk);
        cs = 1'b1; rsel = 1'b1; rd = 1'b1;
        rx_valid = 1'b1; rx_data = 8'h77; rx_ferr = 1'b1;
        #2 chk("R10 read shows old bits", {24'd0, bus_dout}, 32'h01);
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; rx_valid = 1'b0; rx_ferr = 1'b0;
        bus_read(1'b1, rv, roe);
        chk("R10 new error survives", {24'd0, rv}, 32'h0B);
        bus_read(1'b1, rv, roe);
        chk("R10 cleared after", {24'd0, rv}, 32'h03);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule